// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block is a watchdog that counts clock-enable ticks from one of two sources: a dedicated low-speed oscillator enable or a system-clock enable. The ticks pass through a power-of-two prescaler, whose ratio a 3-bit select sets, into a main counter of parameterised length. Software must clear the watchdog before the main counter wraps. If it does not, the block raises a one-cycle reset request.

The kind of request depends on the halt indicator at the moment of overflow. While the device is running, an overflow requests a full chip reset. While the device is halted, it requests only a warm reset, which zeroes the program counter and the stack pointer. Both cases also give a timeout pulse to the reset-status logic. The system clock stops in halt, so a watchdog fed from the system enable freezes during halt. A watchdog fed from the dedicated oscillator keeps counting.

Top module: `wdt_guard`

## Requirements
- R1: With `src_sel`=1 every `osc_tick` counts, whether or not `halted` is set. With `src_sel`=0 a `sys_tick` counts only while `halted`=0. During halt on the system source the watchdog produces no request, however long the halt lasts.
- R2: `div_sel` value k sets the division ratio to 2^k. The first overflow after a clear falls on tick number 2^k * 2^CNT_W, which is 256 ticks for k=0 with the default CNT_W=8.
- R3: Three events clear both the prescaler and the main counter: `rst_n` low at a clock edge (synchronous), `clr_cmd` high, or `halt_enter` high. After a clear the next overflow needs a full period again.
- R4: An overflow while `halted`=0 raises `full_rst_req` for exactly one cycle, in the cycle after the edge that samples the final tick. `warm_rst_req` stays low.
- R5: An overflow while `halted`=1 raises `warm_rst_req` for exactly one cycle with the same timing. `full_rst_req` stays low.
- R6: `timeout_pulse` is high for one cycle together with each request. The counter then wraps to zero, and the next overflow comes one full period later without any clear.
- R7: If a clear and the overflowing tick fall in the same cycle, the clear wins and no request or timeout pulse is raised.
- R8: A change of `div_sel` does not clear the prescaler. For example, 7 ticks at k=3 followed by a switch to k=2 give the first overflow on the 1021st tick after the switch.
- R9: While `rst_n` is low and in the cycle after it, all three outputs are low.
- R10: With `div_sel`=7 (1:128) the timeout reaches its maximum of 32768 ticks at the default length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| osc_tick | input | 1 | Enable from the dedicated low-speed oscillator |
| sys_tick | input | 1 | Enable from the system clock |
| src_sel | input | 1 | 1 selects osc_tick, 0 selects sys_tick |
| div_sel | input | 3 | Prescaler select, ratio 2^div_sel |
| clr_cmd | input | 1 | Clear-watchdog command strobe |
| halt_enter | input | 1 | Halt-entry strobe, clears the watchdog |
| halted | input | 1 | High while the device is in halt |
| full_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request (program counter and stack pointer) |
| timeout_pulse | output | 1 | One-cycle timeout indication for the reset-status logic |

## Verification
The assertions assume that `halted` is steady across an overflow tick and that the tick enables are single-cycle qualifiers, not clocks. They also assume that `div_sel` changes only between ticks. The bench drives every input at the falling edge and holds `halted` and `div_sel` constant while it measures a period. It changes `div_sel` only in the prescaler-retention test, and then at a falling edge. The clear commands are timed to land exactly on the overflowing tick, and the bench confirms there that the clear takes priority.

// File: rtl/wdt_guard_pkg.sv
// Package wdt_guard_pkg
// Holds the constants shared by the watchdog modules.
// Assumes the select field is narrow enough that 2^SEL_W-1 prescaler bits stay small.
package wdt_guard_pkg;
    localparam int SEL_W_DEF = 3;
    localparam int CNT_W_DEF = 8;

    // Number of prescaler bits that a select of width w needs.
    function automatic int pre_bits(input int w);
        return (1 << w) - 1;
    endfunction
endpackage

// File: rtl/wdt_tick_src.sv
// Module wdt_tick_src
// Picks the tick source for the watchdog. The system-clock enable is
// masked during halt because the system clock is stopped there.
// Assumes both enables are one-cycle qualifiers in the clk domain.
module wdt_tick_src (
    input  logic src_sel,
    input  logic osc_tick,
    input  logic sys_tick,
    input  logic halted,
    output logic tick
);
    // Source multiplexer with the halt mask on the system path.
    always_comb begin
        if (src_sel) tick = osc_tick;
        else         tick = sys_tick & ~halted;
    end
endmodule

// File: rtl/wdt_prescaler.sv
// Module wdt_prescaler
// A free-running binary prescaler that advances on each tick. It gives a
// stage strobe when the low div_sel bits are all ones, which divides the
// tick rate by 2^div_sel. Changing div_sel does not clear it.
// Assumes clr takes priority over tick.
module wdt_prescaler #(
    parameter int SEL_W = wdt_guard_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] div_sel,
    output logic             stage
);
    localparam int PRE_W = wdt_guard_pkg::pre_bits(SEL_W);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] low_mask;
    logic [PRE_W-1:0] covered;

    // One mask bit per prescaler stage, set when the stage lies below the select.
    genvar g;
    generate
        for (g = 0; g < PRE_W; g++) begin : g_mask
            assign low_mask[g] = (g < int'(div_sel));
            assign covered[g]  = pre_cnt[g] | ~low_mask[g];
        end
    endgenerate

    // The stage strobe fires when all selected low bits are ones.
    assign stage = tick & (&covered);

    // Prescaler register: cleared by reset or clear, counts up on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_cnt <= '0;
        else if (tick)     pre_cnt <= pre_cnt + 1'b1;
    end

    AST_PRE_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
                      clr |=> (pre_cnt == '0));                    // R3
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                      (!clr && !tick) |=> $stable(pre_cnt));        // R1
    AST_PRE_SEL:  assert property (@(posedge clk) disable iff (!rst_n)
                      (tick && div_sel == '0) |-> stage);           // R2
endmodule

// File: rtl/wdt_main_count.sv
// Module wdt_main_count
// The main watchdog counter. It advances on each prescaler strobe and flags
// an overflow on the strobe that finds it full, then wraps to zero.
// Assumes clr suppresses the overflow in the same cycle.
module wdt_main_count #(
    parameter int CNT_W = wdt_guard_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic             ovf,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Overflow qualifier: a strobe on a full counter, unless a clear is present.
    assign ovf = step & (count == CNT_MAX) & ~clr;

    // Counter register; the natural wrap returns it to zero after the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (step)     count <= count + 1'b1;
    end

    AST_CNT_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
                      clr |=> (count == '0));                       // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                      ovf |=> (count == '0));                       // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                      (!clr && !step) |=> $stable(count));          // R2
endmodule

// File: rtl/wdt_req_gen.sv
// Module wdt_req_gen
// Turns an overflow into registered one-cycle requests. Running gives a full
// reset request, halted gives a warm reset request, and both raise timeout.
// Assumes halted is stable across the overflow cycle.
module wdt_req_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ovf,
    input  logic halted,
    output logic full_rst_req,
    output logic warm_rst_req,
    output logic timeout_pulse
);
    // Output registers, one pulse per overflow, split by the halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_rst_req  <= 1'b0;
            warm_rst_req  <= 1'b0;
            timeout_pulse <= 1'b0;
        end else begin
            full_rst_req  <= ovf & ~halted;
            warm_rst_req  <= ovf & halted;
            timeout_pulse <= ovf;
        end
    end

    AST_REQ_EXCL:  assert property (@(posedge clk) disable iff (!rst_n)
                       !(full_rst_req && warm_rst_req));            // R5
    AST_FULL_ONE:  assert property (@(posedge clk) disable iff (!rst_n)
                       full_rst_req |=> !full_rst_req);             // R4
    AST_WARM_ONE:  assert property (@(posedge clk) disable iff (!rst_n)
                       warm_rst_req |=> !warm_rst_req);             // R5
    AST_CLR_WINS:  assert property (@(posedge clk) disable iff (!rst_n)
                       clr |=> !timeout_pulse);                     // R7
    AST_TMO_PAIR:  assert property (@(posedge clk) disable iff (!rst_n)
                       timeout_pulse |-> (full_rst_req || warm_rst_req)); // R6
endmodule

// File: rtl/wdt_guard.sv
// Module wdt_guard (top)
// The watchdog: a source select, a power-of-two prescaler, the main counter
// and the request generator. The clear command and halt entry both clear it.
// Assumes all strobes are synchronous to clk and rst_n is synchronous active-low.
module wdt_guard #(
    parameter int SEL_W = wdt_guard_pkg::SEL_W_DEF,
    parameter int CNT_W = wdt_guard_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             sys_tick,
    input  logic             src_sel,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             clr_cmd,
    input  logic             halt_enter,
    input  logic             halted,
    output logic             full_rst_req,
    output logic             warm_rst_req,
    output logic             timeout_pulse
);
    logic             tick;
    logic             stage;
    logic             ovf;
    logic             clr;
    logic [CNT_W-1:0] count;

    // Combined clear: a software command or entry into halt.
    assign clr = clr_cmd | halt_enter;

    wdt_tick_src u_src (
        .src_sel (src_sel),
        .osc_tick(osc_tick),
        .sys_tick(sys_tick),
        .halted  (halted),
        .tick    (tick)
    );

    wdt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .tick   (tick),
        .div_sel(div_sel),
        .stage  (stage)
    );

    wdt_main_count #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (stage),
        .ovf  (ovf),
        .count(count)
    );

    wdt_req_gen u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .ovf          (ovf),
        .halted       (halted),
        .full_rst_req (full_rst_req),
        .warm_rst_req (warm_rst_req),
        .timeout_pulse(timeout_pulse)
    );

    AST_SYS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
                        (!src_sel && halted && !clr) |=> $stable(count)); // R1
    AST_RST_QUIET:  assert property (@(posedge clk)
                        !rst_n |=> !(full_rst_req || warm_rst_req || timeout_pulse)); // R9
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       sys_tick = 1'b0;
    logic       src_sel = 1'b1;
    logic [2:0] div_sel = 3'd0;
    logic       clr_cmd = 1'b0;
    logic       halt_enter = 1'b0;
    logic       halted = 1'b0;
    logic       full_rst_req, warm_rst_req, timeout_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_guard dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sys_tick(sys_tick),
        .src_sel(src_sel), .div_sel(div_sel), .clr_cmd(clr_cmd),
        .halt_enter(halt_enter), .halted(halted),
        .full_rst_req(full_rst_req), .warm_rst_req(warm_rst_req),
        .timeout_pulse(timeout_pulse)
    );

    // Vector: [7:5] div_sel, [4] halted, [3] src_sel, [2] pulse expected
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 1'b1, 1'b1, 2'b00},   // R2 R4 osc running
        {3'd1, 1'b1, 1'b1, 1'b1, 2'b00},   // R1 R5 osc halted
        {3'd2, 1'b0, 1'b0, 1'b1, 2'b00},   // R1 R4 sys running
        {3'd3, 1'b1, 1'b0, 1'b0, 2'b00},   // R1 sys halted, frozen
        {3'd0, 1'b1, 1'b1, 1'b1, 2'b00},   // R5 osc halted k=0
        {3'd3, 1'b0, 1'b1, 1'b1, 2'b00}    // R2 k=3
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply a clear command for one cycle; ends at a falling edge with ticks on.
    task automatic do_clear();
        @(negedge clk);
        osc_tick = 1'b0; sys_tick = 1'b0; clr_cmd = 1'b1;
        @(negedge clk);
        clr_cmd = 1'b0; osc_tick = 1'b1; sys_tick = 1'b1;
    endtask

    // Count cycles with ticks on until the first output pulse, up to limit.
    task automatic measure(input int limit, output int n, output logic f,
                           output logic w, output logic t);
        n = 0; f = 0; w = 0; t = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (full_rst_req || warm_rst_req || timeout_pulse) begin
                n = i; f = full_rst_req; w = warm_rst_req; t = timeout_pulse;
                return;
            end
        end
    endtask

    // Run n tick cycles and report any pulse in them as a failure.
    task automatic run_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (full_rst_req || warm_rst_req || timeout_pulse) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: bench did not finish actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, exp;
        logic f, w, t;

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!full_rst_req && !warm_rst_req && !timeout_pulse, "R9 reset quiet",
            {full_rst_req, warm_rst_req, timeout_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!full_rst_req && !warm_rst_req && !timeout_pulse, "R9 after release",
            {full_rst_req, warm_rst_req, timeout_pulse}, 0);

        // Vector table: R1 R2 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            div_sel = VEC[v][7:5];
            halted  = VEC[v][4];
            src_sel = VEC[v][3];
            exp = 1 << (int'(VEC[v][7:5]) + 8);
            do_clear();
            measure(exp + 16, n, f, w, t);
            if (VEC[v][2]) begin
                chk(n == exp, "R2 period", n, exp);
                chk(f == !VEC[v][4], "R4 full request", f, !VEC[v][4]);
                chk(w == VEC[v][4], "R5 warm request", w, VEC[v][4]);
                chk(t == 1'b1, "R6 timeout pulse", t, 1);
                @(negedge clk);
                chk(!full_rst_req && !warm_rst_req && !timeout_pulse, "R6 single cycle",
                    {full_rst_req, warm_rst_req, timeout_pulse}, 0);
            end else begin
                chk(n == 0, "R1 sys source frozen in halt", n, 0);
            end
        end
        halted = 1'b0; src_sel = 1'b1;

        // R6: wrap and second period without clear
        div_sel = 3'd0;
        do_clear();
        measure(300, n, f, w, t);
        chk(n == 256, "R6 first period", n, 256);
        measure(300, n, f, w, t);
        chk(n == 256, "R6 wrap period", n, 256);

        // R3: clear command mid-count restarts
        do_clear();
        run_quiet(200, "R3 no early pulse");
        do_clear();
        measure(300, n, f, w, t);
        chk(n == 256, "R3 clr_cmd restart", n, 256);

        // R3: halt entry clears
        do_clear();
        run_quiet(200, "R3 no early pulse");
        @(negedge clk); halt_enter = 1'b1;
        @(negedge clk); halt_enter = 1'b0;
        measure(300, n, f, w, t);
        chk(n == 256 && f, "R3 halt_enter restart", n, 256);

        // R3: external reset mid-count
        do_clear();
        run_quiet(200, "R3 no early pulse");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        measure(300, n, f, w, t);
        chk(n == 256, "R3 rst_n restart", n, 256);

        // R7: clear on the overflowing tick wins
        do_clear();
        run_quiet(255, "R7 before overflow");
        clr_cmd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_cmd = 1'b0;
        chk(!full_rst_req && !warm_rst_req && !timeout_pulse, "R7 clear wins",
            {full_rst_req, warm_rst_req, timeout_pulse}, 0);
        measure(300, n, f, w, t);
        chk(n == 256, "R7 period after clear", n, 256);

        // R8: select change keeps the prescaler
        div_sel = 3'd3;
        do_clear();
        run_quiet(7, "R8 setup");
        div_sel = 3'd2;
        measure(1100, n, f, w, t);
        chk(n == 1021, "R8 prescaler kept", n, 1021);

        // R10: longest timeout
        div_sel = 3'd7;
        do_clear();
        measure(33000, n, f, w, t);
        chk(n == 32768 && f, "R10 longest timeout", n, 32768);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule